// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for an embedded controller. Software programs it through one 16-bit control word. Every change to that word has to be preceded by a two-word unlock key. The counter is restarted by a second, separate two-word keep-alive key, written to the same address. The timeout length is selected by an 8-bit one-hot field. Each bit picks a power-of-two number of clocks: the lowest bit gives a short period and the other seven give a ladder of long periods.

When the count runs out, the block raises a sticky interrupt flag. If reset is enabled, it also emits a one-cycle system reset pulse and then falls back to the disabled state with the count at zero. Without reset enabled it wraps and keeps timing. The running count can be read as a low half and a high half.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the control readback, both count halves, `irq` and `sys_rst` are all zero.
- R2: A write is taken as control data only when it directly follows the words 0x3333 and 0xCCCC, in that order. That write is consumed and sets enable (bit 15), reset-enable (bit 14) and the exponent field (bits 7:0). The readback is {enable, reset-enable, 0, irq flag, 0000, exponent}.
- R3: A write that is not the expected next key word returns the unlock checker to idle, with one exception: 0x3333 re-arms it. A write that is not unlocked leaves the control state unchanged.
- R4: Writing 0xAAAA and then 0x5555 zeroes the count. Any other word between them cancels the refresh and leaves the count unchanged.
- R5: With exponent bit 0 set, the timeout is 2^SHORT_EXP clocks. With bit k (k from 1 to 7) set, it is 2^(LONG_BASE+k-1) clocks. The count reaches the timeout minus one, and the following clock expires it.
- R6: An exponent of zero or with more than one bit set holds the count and never expires.
- R7: Expiry sets the irq flag (readback bit 12), and the flag stays set. Only an unlocked control write with bit 12 = 1 clears it.
- R8: With reset-enable set, expiry gives a `sys_rst` pulse exactly one cycle long. In that same cycle the enable bit reads 0 and the count reads 0.
- R9: With `rd_sel` = 1 the read returns count bits LO_W-1:0, and with `rd_sel` = 2 it returns the bits above them. With `rd_sel` = 0 it returns the control word.
- R10: Without reset-enable, expiry leaves the watchdog enabled and the count restarts from zero.
- R11: While disabled, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe to the control address |
| wr_data | input | 16 | Write word |
| rd_sel | input | 2 | Read select: 0 control, 1 count low, 2 count high |
| rd_data | output | 16 | Read word |
| irq | output | 1 | Sticky timeout flag |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
A key checker left armed or unlocked in the wrong state shows up on the very next write. A stray word either changes the control readback or fails to change it in the same cycle. A wrong terminal count from the exponent decode shifts the moment `irq` and `sys_rst` rise by at least one clock. A sweep over every period and over all 256 exponent values exposes it exactly. A counter that fails to hold or clear shows up immediately in the count halves. The bench reads them after each key and control sequence.

// File: rtl/keyed_wdog_pkg.sv
// Shared constants for the keyed watchdog: key words and control bit positions.
package keyed_wdog_pkg;
    localparam logic [15:0] KEY_UNLOCK_A  = 16'h3333;
    localparam logic [15:0] KEY_UNLOCK_B  = 16'hCCCC;
    localparam logic [15:0] KEY_REFRESH_A = 16'hAAAA;
    localparam logic [15:0] KEY_REFRESH_B = 16'h5555;

    localparam int unsigned BIT_EN     = 15;
    localparam int unsigned BIT_RST_EN = 14;
    localparam int unsigned BIT_IRQ    = 12;
    localparam int unsigned EXP_W      = 8;

    typedef enum logic [1:0] {
        RD_CTRL = 2'd0,
        RD_LO   = 2'd1,
        RD_HI   = 2'd2,
        RD_NONE = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/keyed_wdog_keyseq.sv
// Two-word key sequence checker.
// Watches every write. After FIRST_W it arms. If the next write is SECOND_W it
// produces a one-cycle hit (combinational with that write). Any other word
// disarms it, except FIRST_W, which re-arms it. A flushed write (consumed
// elsewhere) always disarms it.
// Assumes: at most one write per cycle.
module keyed_wdog_keyseq #(
    parameter logic [15:0] FIRST_W  = 16'h0000,
    parameter logic [15:0] SECOND_W = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        flush,
    output logic        hit
);
    logic armed_q;

    // Completion of the sequence on the current write.
    assign hit = wr_en && !flush && armed_q && (wr_data == SECOND_W);

    // Arm on the first word; every other write (or a flush) disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_en) begin
            armed_q <= !flush && (wr_data == FIRST_W);
        end
    end
endmodule

// File: rtl/keyed_wdog_limit.sv
// Exponent decode: converts the one-hot select into the terminal count
// (timeout - 1) and a validity flag.
// Bit 0 selects 2^SHORT_EXP. Bit k (k >= 1) selects 2^(LONG_BASE+k-1).
// Assumes: SHORT_EXP < LONG_BASE, and CNT_W holds the largest terminal count.
module keyed_wdog_limit #(
    parameter int unsigned SHORT_EXP = 14,
    parameter int unsigned LONG_BASE = 24,
    parameter int unsigned CNT_W     = 31
) (
    input  logic [7:0]       exp_sel,
    output logic             exp_ok,
    output logic [CNT_W-1:0] last
);
    logic [CNT_W-1:0] term [8];

    // One masked terminal count per select bit.
    for (genvar k = 0; k < 8; k++) begin : g_term
        localparam int unsigned E = (k == 0) ? SHORT_EXP : LONG_BASE + k - 1;
        localparam logic [63:0] LAST64 = (64'd1 << E) - 64'd1;
        assign term[k] = exp_sel[k] ? LAST64[CNT_W-1:0] : '0;
    end

    // A select is usable only if exactly one bit is set.
    assign exp_ok = (exp_sel != 8'd0) && ((exp_sel & (exp_sel - 8'd1)) == 8'd0);

    // Merge the terms; only one can be non-zero when exp_ok is true.
    always_comb begin
        last = '0;
        for (int k = 0; k < 8; k++) begin
            last = last | term[k];
        end
    end
endmodule

// File: rtl/keyed_wdog_counter.sv
// Timeout counter. Counts while run is high and expires on the clock where the
// count equals last. Expiry and refresh both return it to zero. Refresh wins
// over an expiry in the same cycle.
// Assumes: last is stable while run is high, apart from control writes.
module keyed_wdog_counter #(
    parameter int unsigned CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             refresh,
    input  logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] count_q;

    assign count  = count_q;
    assign expire = run && !refresh && (count_q == last);

    // Advance, clear on refresh or expiry, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (refresh || expire) begin
            count_q <= '0;
        end else if (run) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/keyed_wdog.sv
// Keyed watchdog top. Holds the control state, the unlock window, the irq flag
// and the reset pulse. Routes reads of the control word and the two count halves.
// Assumes: a single write port aimed at the control address; reads are combinational.
module keyed_wdog #(
    parameter int unsigned SHORT_EXP = 14,
    parameter int unsigned LONG_BASE = 24,
    parameter int unsigned LO_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [15:0] rd_data,
    output logic        irq,
    output logic        sys_rst
);
    import keyed_wdog_pkg::*;

    localparam int unsigned CNT_W  = LONG_BASE + 7;
    localparam int unsigned VIEW_W = 2 * LO_W;

    logic             en_q, rst_en_q, irq_q, open_q, sys_rst_q;
    logic [7:0]       exp_q;
    logic             ctl_wr, unlock_hit, refresh, exp_ok, run, expire;
    logic [CNT_W-1:0] last, count;
    logic [VIEW_W-1:0] count_ext;

    // The write right after a completed unlock is the control write.
    assign ctl_wr = wr_en && open_q;
    assign run    = en_q && exp_ok;

    keyed_wdog_keyseq #(.FIRST_W(KEY_UNLOCK_A), .SECOND_W(KEY_UNLOCK_B)) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flush(open_q), .hit(unlock_hit)
    );

    keyed_wdog_keyseq #(.FIRST_W(KEY_REFRESH_A), .SECOND_W(KEY_REFRESH_B)) u_refresh (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flush(open_q), .hit(refresh)
    );

    keyed_wdog_limit #(.SHORT_EXP(SHORT_EXP), .LONG_BASE(LONG_BASE), .CNT_W(CNT_W)) u_limit (
        .exp_sel(exp_q), .exp_ok(exp_ok), .last(last)
    );

    keyed_wdog_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .run(run), .refresh(refresh),
        .last(last), .count(count), .expire(expire)
    );

    // Unlock window: opens on a key hit, closes on the next write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (wr_en) begin
            open_q <= unlock_hit;
        end
    end

    // Control fields: loaded by a control write; a reset expiry drops enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            rst_en_q <= 1'b0;
            exp_q    <= '0;
        end else begin
            if (ctl_wr) begin
                en_q     <= wr_data[BIT_EN];
                rst_en_q <= wr_data[BIT_RST_EN];
                exp_q    <= wr_data[EXP_W-1:0];
            end
            if (expire && rst_en_q) begin
                en_q <= 1'b0;
            end
        end
    end

    // Sticky flag: set on expiry (wins), cleared by write-one in a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (expire) begin
            irq_q <= 1'b1;
        end else if (ctl_wr && wr_data[BIT_IRQ]) begin
            irq_q <= 1'b0;
        end
    end

    // Reset request: one registered cycle per expiry with reset enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst_q <= 1'b0;
        end else begin
            sys_rst_q <= expire && rst_en_q;
        end
    end

    assign irq       = irq_q;
    assign sys_rst   = sys_rst_q;
    assign count_ext = VIEW_W'(count);

    // Read mux: control word or one half of the count.
    always_comb begin
        case (rd_sel_e'(rd_sel))
            RD_CTRL: rd_data = {en_q, rst_en_q, 1'b0, irq_q, 4'b0000, exp_q};
            RD_LO:   rd_data = 16'(count_ext[LO_W-1:0]);
            RD_HI:   rd_data = 16'(count_ext[VIEW_W-1:LO_W]);
            default: rd_data = 16'h0000;
        endcase
    end
endmodule

// File: rtl/keyed_wdog_chk.sv
// Property checker for keyed_wdog, attached with bind below.
// Observes the control state, the count and the internal strobes.
module keyed_wdog_chk #(
    parameter int unsigned CNT_W = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             bit12,
    input logic             refresh,
    input logic             expire,
    input logic             en_q,
    input logic             rst_en_q,
    input logic [7:0]       exp_q,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             sys_rst
);
    // R8: the reset pulse lasts one cycle.
    p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> !sys_rst);

    // R8: while the pulse is out, the watchdog is off and the count is zero.
    p_rst_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> (!en_q && count == '0));

    // R7: the flag only falls after a control write that carried bit 12.
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(ctl_wr) && $past(bit12)));

    // R4: a refresh leaves the count at zero.
    p_refresh_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (count == '0));

    // R6: an unusable exponent holds the count.
    p_hold_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(exp_q) != 1 && !refresh) |=> $stable(count));

    // R6: an unusable exponent never produces a reset pulse.
    p_no_expire_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(exp_q) != 1) |=> !sys_rst);

    // R3: without a control write or a reset expiry, control fields stay put.
    p_ctrl_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && !(expire && rst_en_q)) |=> $stable({en_q, rst_en_q, exp_q}));

    // R11: a disabled watchdog holds its count unless refreshed.
    p_hold_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !refresh) |=> $stable(count));
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .bit12(wr_data[12]),
    .refresh(refresh), .expire(expire), .en_q(en_q), .rst_en_q(rst_en_q),
    .exp_q(exp_q), .count(count), .irq(irq), .sys_rst(sys_rst)
);

// File: tb/keyed_wdog_bench.sv
// Self-checking bench for keyed_wdog with a small configuration.
// Periods are 8 (bit 0) and 32..2048 (bits 1..7). The count view is split at 6 bits.
module keyed_wdog_bench;
    localparam int unsigned SHORT_EXP = 3;
    localparam int unsigned LONG_BASE = 5;
    localparam int unsigned LO_W      = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0000;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        irq, sys_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    keyed_wdog #(.SHORT_EXP(SHORT_EXP), .LONG_BASE(LONG_BASE), .LO_W(LO_W)) u_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .sys_rst(sys_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write, one clock edge; entered and left at a falling edge.
    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0000;
    endtask

    task automatic rd(input logic [1:0] s, output int v);
        rd_sel = s; #1; v = int'(rd_data);
    endtask

    task automatic ctrl(input logic [15:0] d);
        wr(16'h3333); wr(16'hCCCC); wr(d);
    endtask

    task automatic refresh();
        wr(16'hAAAA); wr(16'h5555);
    endtask

    function automatic int limit_of(input int k);
        return (k == 0) ? (1 << SHORT_EXP) : (1 << (LONG_BASE + k - 1));
    endfunction

    function automatic int count_of();
        return int'(u_keyed_wdog.rd_data); // unused helper guard
    endfunction

    int v, lo, hi;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 count lo", v, 0);
        rd(2'd2, v); chk("R1 count hi", v, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 sys_rst", int'(sys_rst), 0);

        // R3 plain write ignored
        wr(16'hC0FF); rd(2'd0, v); chk("R3 plain write", v, 0);
        // R3 wrong second word breaks the unlock
        wr(16'h3333); wr(16'h1234); wr(16'hCCCC); wr(16'h8001);
        rd(2'd0, v); chk("R3 broken unlock", v, 0);
        // R3 repeated first word re-arms
        wr(16'h3333); wr(16'h3333); wr(16'hCCCC); wr(16'h0004);
        rd(2'd0, v); chk("R3 re-arm", v, 16'h0004);
        // R2 control write consumes the word, next key word is data-free
        ctrl(16'h3333); rd(2'd0, v); chk("R2 consumed word", v, 16'h0033);
        wr(16'hCCCC); rd(2'd0, v); chk("R2 lone second key", v, 16'h0033);
        // R2 field masking
        ctrl(16'h6F00); rd(2'd0, v); chk("R2 mask", v, 16'h4000);
        ctrl(16'h0000);

        // R5 R6 exhaustive exponent sweep: count after 3 enabled clocks
        for (int e = 0; e < 256; e++) begin
            ctrl(16'h8000 | 16'(e));
            repeat (3) @(negedge clk);
            rd(2'd1, v);
            chk(($countones(e) == 1) ? "R5 onehot runs" : "R6 invalid holds",
                v, ($countones(e) == 1) ? 3 : 0);
            ctrl(16'h0000);
            refresh();
        end
        rd(2'd1, v); chk("R4 refresh zero", v, 0);
        chk("R6 no irq in sweep", int'(irq), 0);

        // R5 R8 exact period for every select bit, reset enabled
        for (int k = 0; k < 8; k++) begin
            ctrl(16'hC000 | 16'(1 << k));
            repeat (limit_of(k) - 1) @(negedge clk);
            rd(2'd1, lo); rd(2'd2, hi);
            chk("R5 count before expiry", (hi << LO_W) | lo, limit_of(k) - 1);
            chk("R5 no early irq", int'(irq), 0);
            @(negedge clk);
            chk("R8 pulse high", int'(sys_rst), 1);
            chk("R7 irq set", int'(irq), 1);
            rd(2'd0, v); chk("R8 disabled", v, 16'h5000 | (1 << k));
            rd(2'd1, v); chk("R8 count zero", v, 0);
            @(negedge clk);
            chk("R8 single cycle", int'(sys_rst), 0);
            ctrl(16'h1000);
            chk("R7 cleared", int'(irq), 0);
        end

        // R10 no reset: wraps and stays enabled
        ctrl(16'h8001);
        repeat (8) @(negedge clk);
        chk("R10 irq", int'(irq), 1);
        chk("R10 no pulse", int'(sys_rst), 0);
        rd(2'd0, v); chk("R10 still enabled", v, 16'h9001);
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk("R10 wrapped count", v, 4);

        // R7 clearing rules
        ctrl(16'h0000); chk("R7 write zero keeps", int'(irq), 1);
        wr(16'h1000); chk("R7 locked write keeps", int'(irq), 1);
        ctrl(16'h1000); chk("R7 write one clears", int'(irq), 0);
        refresh();

        // R9 R11 R4 held count and split views
        ctrl(16'h8080);
        repeat (100) @(negedge clk);
        ctrl(16'h0000);               // three more running edges: 103
        rd(2'd1, lo); rd(2'd2, hi);
        chk("R9 low half", lo, 103 % 64);
        chk("R9 high half", hi, 103 / 64);
        repeat (5) @(negedge clk);
        rd(2'd1, v); chk("R11 hold", v, 103 % 64);
        wr(16'hAAAA); wr(16'h1111); wr(16'h5555);
        rd(2'd1, lo); rd(2'd2, hi);
        chk("R4 broken refresh", (hi << LO_W) | lo, 103);
        refresh();
        rd(2'd1, v); chk("R4 refresh", v, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule